// File: doc/BRIEF.md
# Two-Wire Bus Controller Control Logic

This block is the software-facing control layer of a two-wire serial bus controller that can act as master or slave. Software writes a byte-wide control register and a data register. A separate bit-level engine produces the SCL/SDA waveforms, compares addresses and stretches the clock. That engine reports bus state and events to this block as levels and single-cycle pulses. In return the block drives start, stop and acknowledge requests to the engine, hands it the bytes to transmit, and produces an interrupt line and a DMA request.

A start requested from idle waits until the bus goes free. A start requested while the block already owns the bus is held back. It becomes a repeated start only when software next writes the data register, and that byte goes out as the address and direction byte. The receive acknowledge override fires once and cannot be withdrawn by software. Turning on DMA narrows the interrupt to error and address-match events, and each completed data transaction then produces a DMA pulse.

Top module: `twb_ctrl`

## Requirements
- R1: After reset, `ctl_rdata` is 0x00, `sts_rdata` is 0x00 while the bus is idle and the block is not master, and `start_req`, `stop_req`, `ack_nack`, `irq`, `dma_req` and `tx_load` are all 0.
- R2: Control byte fields: bit0 start, bit1 stop, bit2 interrupt enable, bit3 DMA enable, bit4 NACK-next, bit5 general-call enable (driven on `gcm_en`), bit6 match-interrupt enable, bit7 start-done interrupt enable. Bits 2, 3, 5, 6 and 7 take the written value. Bits 0, 1 and 4 are set by writing 1, and writing 0 to them has no effect.
- R3: A start set while `eng_master` is 0 drives `start_req` only while `eng_busy` is 0, and keeps requesting until the start completes.
- R4: A start set while `eng_master` is 1 arms a repeated start and raises no request. The next data write raises `start_req` in the following cycle and presents that byte with `tx_addr` = 1. Later data writes give `tx_addr` = 0.
- R5: The start bit and any armed repeated start clear on `eng_start_done` or on `eng_berr`.
- R6: Writing the stop bit while master sets it and drives `stop_req`, and the bit clears on `eng_stop_done` or `eng_berr`. A stop written while not master is ignored. Writing start and stop together sets only the stop bit.
- R7: `ack_nack` equals the NACK-next bit while `eng_rx` is 1 and is 0 otherwise. The bit clears after an `eng_ack_cycle` with `eng_rx` = 1, and an acknowledge cycle in transmit mode leaves it set.
- R8: Status byte: bit0 bus busy, bit1 master (both live), bit2 bus error, bit3 NACK received, bit4 address match, bit5 data ready, bit6 slave stop, bit7 start done. Bits 2-7 are sticky, set by engine pulses, and clear by writing 1 to `sts_wdata`. An event in the same cycle as a clear wins.
- R9: With DMA disabled, `irq` is the interrupt enable ANDed with the OR of: bus error, NACK, address match (only with match-interrupt enable), data ready, slave stop, and start done (only with start-done interrupt enable).
- R10: With DMA enabled, `irq` covers only bus error, NACK and gated address match. Data ready, slave stop and start done do not raise it.
- R11: With DMA enabled, each `eng_dready` pulse gives a one-cycle `dma_req` in the next cycle. With DMA disabled, `dma_req` stays 0.
- R12: A data write presents the byte on `tx_byte` with a one-cycle `tx_load` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data |
| ctl_rdata | output | 8 | Control register value |
| dat_wr | input | 1 | Data register write strobe |
| dat_wdata | input | 8 | Data write byte |
| sts_wr | input | 1 | Status write-1-to-clear strobe |
| sts_wdata | input | 8 | Status clear mask |
| sts_rdata | output | 8 | Status byte |
| eng_busy | input | 1 | Bus busy level from engine |
| eng_master | input | 1 | Master level from engine |
| eng_rx | input | 1 | Receiving level from engine |
| eng_berr | input | 1 | Bus error pulse |
| eng_nack | input | 1 | NACK received pulse |
| eng_match | input | 1 | Address match pulse |
| eng_dready | input | 1 | Data transaction done pulse |
| eng_sstop | input | 1 | Stop seen in slave mode pulse |
| eng_start_done | input | 1 | Start condition sent pulse |
| eng_stop_done | input | 1 | Stop condition sent pulse |
| eng_ack_cycle | input | 1 | Acknowledge cycle done pulse |
| start_req | output | 1 | Start request to engine |
| stop_req | output | 1 | Stop request to engine |
| ack_nack | output | 1 | Drive NACK on next acknowledge |
| gcm_en | output | 1 | General-call match enable |
| tx_byte | output | 8 | Byte to transmit |
| tx_load | output | 1 | Byte load pulse |
| tx_addr | output | 1 | Loaded byte is address after repeated start |
| irq | output | 1 | Level interrupt |
| dma_req | output | 1 | DMA request pulse |

## Verification
A stale armed repeated-start flag shows at the ports as `start_req` either staying low after a data write or rising while `eng_busy` is still high. It also shows as `tx_addr` set on a plain data byte, and both are visible one cycle after the write. A stuck or lost NACK-next bit shows on `ack_nack` as soon as `eng_rx` toggles. A wrong sticky flag shows on `irq` and on `sts_rdata` in the cycle after the engine pulse, and the bench exercises it under both DMA settings.

// File: rtl/twb_pkg.sv
package twb_pkg;
  parameter int unsigned DW = 8;
  parameter int unsigned NFLAG = 6;

  // control bit positions
  localparam int unsigned C_START = 0;
  localparam int unsigned C_STOP  = 1;
  localparam int unsigned C_IEN   = 2;
  localparam int unsigned C_DMA   = 3;
  localparam int unsigned C_NACK  = 4;
  localparam int unsigned C_GCM   = 5;
  localparam int unsigned C_MIEN  = 6;
  localparam int unsigned C_SIEN  = 7;

  // sticky flag indices (status byte bit = index + 2)
  localparam int unsigned F_BERR  = 0;
  localparam int unsigned F_NACK  = 1;
  localparam int unsigned F_MATCH = 2;
  localparam int unsigned F_DRDY  = 3;
  localparam int unsigned F_SSTOP = 4;
  localparam int unsigned F_STDN  = 5;
endpackage

// File: rtl/twb_rst_sync.sv
module twb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/twb_ctl_reg.sv
module twb_ctl_reg
  import twb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  logic [DW-1:0] ctl_wdata,
  input  logic          dat_wr,
  input  logic          eng_busy,
  input  logic          eng_master,
  input  logic          eng_rx,
  input  logic          eng_berr,
  input  logic          eng_start_done,
  input  logic          eng_stop_done,
  input  logic          eng_ack_cycle,
  output logic [DW-1:0] ctl_q,
  output logic          rs_arm,
  output logic          start_req,
  output logic          stop_req,
  output logic          ack_nack
);
  logic [DW-1:0] ctl_d;
  logic          arm_q, arm_d;
  logic          go_q, go_d;
  logic          start_clr, stop_clr, ack_clr;
  logic          wr_start, wr_stop;

  assign start_clr = eng_start_done | eng_berr;
  assign stop_clr  = eng_stop_done | eng_berr;
  assign ack_clr   = eng_ack_cycle & eng_rx;
  assign wr_stop   = ctl_wr & ctl_wdata[C_STOP] & eng_master;
  assign wr_start  = ctl_wr & ctl_wdata[C_START] & ~ctl_wdata[C_STOP];

  always_comb begin
    ctl_d = ctl_q;
    arm_d = arm_q;
    go_d  = go_q;
    // hardware clears first, software sets after
    if (start_clr) begin
      ctl_d[C_START] = 1'b0;
      arm_d          = 1'b0;
      go_d           = 1'b0;
    end
    if (stop_clr) ctl_d[C_STOP] = 1'b0;
    if (ack_clr)  ctl_d[C_NACK] = 1'b0;
    if (ctl_wr) begin
      ctl_d[C_IEN]  = ctl_wdata[C_IEN];
      ctl_d[C_DMA]  = ctl_wdata[C_DMA];
      ctl_d[C_GCM]  = ctl_wdata[C_GCM];
      ctl_d[C_MIEN] = ctl_wdata[C_MIEN];
      ctl_d[C_SIEN] = ctl_wdata[C_SIEN];
      if (ctl_wdata[C_NACK]) ctl_d[C_NACK] = 1'b1;
    end
    if (wr_stop) ctl_d[C_STOP] = 1'b1;
    if (wr_start) begin
      ctl_d[C_START] = 1'b1;
      if (eng_master && !ctl_q[C_START]) arm_d = 1'b1;
    end
    if (dat_wr && arm_q && !start_clr) go_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      arm_q <= 1'b0;
      go_q  <= 1'b0;
    end else begin
      ctl_q <= ctl_d;
      arm_q <= arm_d;
      go_q  <= go_d;
    end
  end

  assign rs_arm    = arm_q;
  assign start_req = ctl_q[C_START] & (arm_q ? go_q : ~eng_busy);
  assign stop_req  = ctl_q[C_STOP];
  assign ack_nack  = ctl_q[C_NACK] & eng_rx;
endmodule

// File: rtl/twb_txdat.sv
module twb_txdat
  import twb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dat_wr,
  input  logic [DW-1:0] dat_wdata,
  input  logic          rs_arm,
  output logic [DW-1:0] tx_byte,
  output logic          tx_load,
  output logic          tx_addr
);
  logic [DW-1:0] byte_d;
  logic          load_d, addr_d;

  always_comb begin
    byte_d = tx_byte;
    load_d = dat_wr;
    addr_d = dat_wr & rs_arm;
    if (dat_wr) byte_d = dat_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_byte <= '0;
      tx_load <= 1'b0;
      tx_addr <= 1'b0;
    end else begin
      tx_byte <= byte_d;
      tx_load <= load_d;
      tx_addr <= addr_d;
    end
  end
endmodule

// File: rtl/twb_flags.sv
module twb_flags
  import twb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] ev,
  input  logic             clr_wr,
  input  logic [NFLAG-1:0] clr_mask,
  output logic [NFLAG-1:0] flg
);
  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    logic d;
    always_comb d = ev[i] | (flg[i] & ~(clr_wr & clr_mask[i]));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flg[i] <= 1'b0;
      else        flg[i] <= d;
    end
  end
endmodule

// File: rtl/twb_evt.sv
module twb_evt
  import twb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] flg,
  input  logic             inten,
  input  logic             dmaen,
  input  logic             mien,
  input  logic             sien,
  input  logic             eng_dready,
  output logic             irq,
  output logic             dma_req
);
  logic err_src, full_src, dma_d;

  always_comb begin
    err_src  = flg[F_BERR] | flg[F_NACK] | (flg[F_MATCH] & mien);
    full_src = err_src | flg[F_DRDY] | flg[F_SSTOP] | (flg[F_STDN] & sien);
    irq      = inten & (dmaen ? err_src : full_src);
    dma_d    = dmaen & eng_dready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dma_req <= 1'b0;
    else        dma_req <= dma_d;
  end
endmodule

// File: rtl/twb_ctrl.sv
module twb_ctrl
  import twb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  logic [DW-1:0] ctl_wdata,
  output logic [DW-1:0] ctl_rdata,
  input  logic          dat_wr,
  input  logic [DW-1:0] dat_wdata,
  input  logic          sts_wr,
  input  logic [DW-1:0] sts_wdata,
  output logic [DW-1:0] sts_rdata,
  input  logic          eng_busy,
  input  logic          eng_master,
  input  logic          eng_rx,
  input  logic          eng_berr,
  input  logic          eng_nack,
  input  logic          eng_match,
  input  logic          eng_dready,
  input  logic          eng_sstop,
  input  logic          eng_start_done,
  input  logic          eng_stop_done,
  input  logic          eng_ack_cycle,
  output logic          start_req,
  output logic          stop_req,
  output logic          ack_nack,
  output logic          gcm_en,
  output logic [DW-1:0] tx_byte,
  output logic          tx_load,
  output logic          tx_addr,
  output logic          irq,
  output logic          dma_req
);
  localparam int unsigned LIVE = DW - NFLAG;

  logic             rst_sn;
  logic [DW-1:0]    ctl_q;
  logic             rs_arm;
  logic [NFLAG-1:0] ev, flg;

  assign ev = {eng_start_done, eng_sstop, eng_dready, eng_match, eng_nack, eng_berr};

  twb_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  twb_ctl_reg u_ctl (
    .clk(clk), .rst_n(rst_sn), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .dat_wr(dat_wr), .eng_busy(eng_busy), .eng_master(eng_master),
    .eng_rx(eng_rx), .eng_berr(eng_berr), .eng_start_done(eng_start_done),
    .eng_stop_done(eng_stop_done), .eng_ack_cycle(eng_ack_cycle),
    .ctl_q(ctl_q), .rs_arm(rs_arm), .start_req(start_req),
    .stop_req(stop_req), .ack_nack(ack_nack)
  );

  twb_txdat u_tx (
    .clk(clk), .rst_n(rst_sn), .dat_wr(dat_wr), .dat_wdata(dat_wdata),
    .rs_arm(rs_arm), .tx_byte(tx_byte), .tx_load(tx_load), .tx_addr(tx_addr)
  );

  twb_flags u_flg (
    .clk(clk), .rst_n(rst_sn), .ev(ev), .clr_wr(sts_wr),
    .clr_mask(sts_wdata[DW-1:LIVE]), .flg(flg)
  );

  twb_evt u_evt (
    .clk(clk), .rst_n(rst_sn), .flg(flg), .inten(ctl_q[C_IEN]),
    .dmaen(ctl_q[C_DMA]), .mien(ctl_q[C_MIEN]), .sien(ctl_q[C_SIEN]),
    .eng_dready(eng_dready), .irq(irq), .dma_req(dma_req)
  );

  assign ctl_rdata = ctl_q;
  assign sts_rdata = {flg, eng_master, eng_busy};
  assign gcm_en    = ctl_q[C_GCM];
endmodule

// File: rtl/twb_ctrl_chk.sv
module twb_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_wr,
  input logic [7:0] ctl_wdata,
  input logic [7:0] ctl_rdata,
  input logic       eng_busy,
  input logic       eng_rx,
  input logic       eng_berr,
  input logic       eng_dready,
  input logic       eng_start_done,
  input logic       eng_ack_cycle,
  input logic       start_req,
  input logic       ack_nack,
  input logic       irq,
  input logic       dma_req,
  input logic       rs_arm
);
  AST_IDLE_START_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && !rs_arm) |-> !eng_busy); // R3
  AST_START_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[0] && (eng_start_done || eng_berr) && !ctl_wr) |=> !ctl_rdata[0]); // R5
  AST_BERR_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    eng_berr |=> !rs_arm); // R5
  AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_wdata[1:0] == 2'b11 && !ctl_rdata[0]) |=> !ctl_rdata[0]); // R6
  AST_ACK_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_ack_cycle && eng_rx && !(ctl_wr && ctl_wdata[4])) |=> !ctl_rdata[4]); // R7
  AST_ACK_TX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_rx |-> !ack_nack); // R7
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ctl_rdata[2]); // R9
  AST_DMA_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_dready && ctl_rdata[3] && !ctl_wr) |=> dma_req); // R11
  AST_DMA_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_rdata[3] && !ctl_wr) |=> !dma_req); // R11
endmodule

bind twb_ctrl twb_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_sn), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
  .ctl_rdata(ctl_rdata), .eng_busy(eng_busy), .eng_rx(eng_rx),
  .eng_berr(eng_berr), .eng_dready(eng_dready),
  .eng_start_done(eng_start_done), .eng_ack_cycle(eng_ack_cycle),
  .start_req(start_req), .ack_nack(ack_nack), .irq(irq),
  .dma_req(dma_req), .rs_arm(rs_arm)
);

// File: tb/tb_twb_ctrl.sv
module tb_twb_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_wr = 0, dat_wr = 0, sts_wr = 0;
  logic [7:0] ctl_wdata = 0, dat_wdata = 0, sts_wdata = 0;
  logic eng_busy = 0, eng_master = 0, eng_rx = 0;
  logic eng_berr = 0, eng_nack = 0, eng_match = 0, eng_dready = 0;
  logic eng_sstop = 0, eng_start_done = 0, eng_stop_done = 0, eng_ack_cycle = 0;
  logic [7:0] ctl_rdata, sts_rdata, tx_byte;
  logic start_req, stop_req, ack_nack, gcm_en, tx_load, tx_addr, irq, dma_req;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  twb_ctrl dut (.*);

  // {ctl byte, events {stdone,sstop,drdy,match,nack,berr}, irq, dma}
  localparam logic [15:0] VEC [14] = '{
    {8'h04, 6'b000001, 1'b1, 1'b0},  // R9 bus error
    {8'h00, 6'b000001, 1'b0, 1'b0},  // R9 enable off
    {8'h04, 6'b000100, 1'b0, 1'b0},  // R9 match not enabled
    {8'h44, 6'b000100, 1'b1, 1'b0},  // R9 match enabled
    {8'h04, 6'b001000, 1'b1, 1'b0},  // R9 data ready
    {8'h0C, 6'b001000, 1'b0, 1'b1},  // R10 data ready under DMA
    {8'h0C, 6'b010000, 1'b0, 1'b0},  // R10 slave stop under DMA
    {8'h04, 6'b010000, 1'b1, 1'b0},  // R9 slave stop
    {8'h04, 6'b100000, 1'b0, 1'b0},  // R9 start done not enabled
    {8'h84, 6'b100000, 1'b1, 1'b0},  // R9 start done enabled
    {8'h8C, 6'b100000, 1'b0, 1'b0},  // R10 start done under DMA
    {8'h0C, 6'b000010, 1'b1, 1'b0},  // R10 NACK under DMA
    {8'h4C, 6'b000100, 1'b1, 1'b0},  // R10 match under DMA
    {8'h08, 6'b001000, 1'b0, 1'b1}   // R11 DMA pulse, no irq
  };

  task automatic check(input string rq, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    ctl_wr = 1; ctl_wdata = v; tick(); ctl_wr = 0; ctl_wdata = 0;
  endtask

  task automatic wr_dat(input logic [7:0] v);
    dat_wr = 1; dat_wdata = v; tick(); dat_wr = 0;
  endtask

  task automatic clr_sts();
    sts_wr = 1; sts_wdata = 8'hFC; tick(); sts_wr = 0; sts_wdata = 0;
  endtask

  task automatic set_ev(input logic [5:0] e);
    {eng_start_done, eng_sstop, eng_dready, eng_match, eng_nack, eng_berr} = e;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 ctl", ctl_rdata, 8'h00);
    check("R1 sts", sts_rdata, 8'h00);
    check("R1 outs", {2'b0, start_req, stop_req, ack_nack, irq, dma_req, tx_load}, 8'h00);

    // table walk: R9 R10 R11
    for (int i = 0; i < 14; i++) begin
      wr_ctl(VEC[i][15:8]);
      set_ev(VEC[i][7:2]);
      tick();
      set_ev(6'b0);
      check($sformatf("R9/R10/R11 vec%0d irq,dma", i), {6'b0, irq, dma_req}, {6'b0, VEC[i][1:0]});
      clr_sts();
    end

    // R2 plain fields and set-only bits
    wr_ctl(8'hEC);
    check("R2 plain fields", ctl_rdata, 8'hEC);
    check("R2 gcm_en", {7'b0, gcm_en}, 8'h01);
    wr_ctl(8'h00);
    check("R2 cleared", ctl_rdata, 8'h00);

    // R8 sticky flags, W1C, live bits
    eng_busy = 1; eng_master = 1;
    set_ev(6'b000011); tick(); set_ev(6'b0);
    check("R8 sticky", sts_rdata, 8'h0F);
    sts_wr = 1; sts_wdata = 8'h04; eng_nack = 1; tick(); sts_wr = 0; eng_nack = 0;
    check("R8 w1c, set wins", sts_rdata, 8'h0B);
    clr_sts();
    check("R8 cleared", sts_rdata, 8'h03);
    eng_master = 0;

    // R3 start from idle with busy bus
    eng_busy = 1;
    wr_ctl(8'h01);
    check("R3 held while busy", {7'b0, start_req}, 8'h00);
    check("R3 start bit", ctl_rdata & 8'h01, 8'h01);
    tick();
    eng_busy = 0; #1;
    check("R3 request when free", {7'b0, start_req}, 8'h01);
    tick();
    check("R3 still requesting", {7'b0, start_req}, 8'h01);
    eng_start_done = 1; eng_master = 1; tick(); eng_start_done = 0;
    check("R5 start cleared by done", {ctl_rdata[0], start_req}, 2'b00);

    // R12 plain data write
    wr_dat(8'h3C);
    check("R12 load", {tx_byte}, 8'h3C);
    check("R12 pulse/addr", {6'b0, tx_load, tx_addr}, 8'h02);
    tick();
    check("R12 pulse ends", {7'b0, tx_load}, 8'h00);

    // R4 deferred repeated start
    wr_ctl(8'h01);
    tick(); tick();
    check("R4 no request while armed", {7'b0, start_req}, 8'h00);
    wr_dat(8'hA1);
    check("R4 request after data", {7'b0, start_req}, 8'h01);
    check("R4 address byte", tx_byte, 8'hA1);
    check("R4 addr flag", {6'b0, tx_load, tx_addr}, 8'h03);
    eng_start_done = 1; tick(); eng_start_done = 0;
    check("R5 repeated start cleared", {ctl_rdata[0], start_req}, 2'b00);
    wr_dat(8'h55);
    check("R4 later byte not address", {6'b0, tx_load, tx_addr}, 8'h02);

    // R5 bus error disarms
    wr_ctl(8'h01);
    eng_berr = 1; tick(); eng_berr = 0;
    check("R5 berr clears start", ctl_rdata & 8'h01, 8'h00);
    wr_dat(8'h77);
    check("R5 no repeated start after berr", {6'b0, start_req, tx_addr}, 8'h00);
    clr_sts();

    // R6 stop priority and stop behaviour
    wr_ctl(8'h03);
    check("R6 stop wins", ctl_rdata & 8'h03, 8'h02);
    check("R6 stop_req", {7'b0, stop_req}, 8'h01);
    eng_stop_done = 1; eng_master = 0; tick(); eng_stop_done = 0;
    check("R6 stop cleared", {ctl_rdata[1], stop_req}, 2'b00);
    wr_ctl(8'h02);
    check("R6 stop ignored when slave", ctl_rdata & 8'h02, 8'h00);

    // R7 one-shot NACK
    eng_rx = 1;
    wr_ctl(8'h10);
    check("R7 nack driven", {7'b0, ack_nack}, 8'h01);
    wr_ctl(8'h00);
    check("R7 write 0 no clear", {7'b0, ack_nack}, 8'h01);
    eng_rx = 0; #1;
    check("R7 quiet in transmit", {7'b0, ack_nack}, 8'h00);
    eng_ack_cycle = 1; tick(); eng_ack_cycle = 0;
    check("R7 kept after tx ack", ctl_rdata & 8'h10, 8'h10);
    eng_rx = 1; eng_ack_cycle = 1; tick(); eng_ack_cycle = 0;
    check("R7 consumed", {ctl_rdata[4], ack_nack}, 2'b00);
    eng_rx = 0;

    // R11 DMA off gives no pulse
    wr_ctl(8'h00);
    eng_dready = 1; tick(); eng_dready = 0;
    check("R11 no dma when off", {7'b0, dma_req}, 8'h00);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule